// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Row Scanner

This block drives the scan of a multiplexed dot-matrix LCD at logic level. It holds a small display memory of 32 lines of 40 pixels, split into four banks of 8 lines. Each scan step selects exactly one display row and places that row's pixel line on the 40 column outputs. A frame consists of 8, 16, 24 or 32 scan steps.

Three settings shape the picture: the scan depth, the bank shown on the top display row, and a display status. The display status can blank the panel, light every dot, pass the memory through, or invert it. Changing the top bank scrolls the picture in steps of one bank. The spare banks can be filled in the background and then brought into view.

Settings from the register side are captured only when a frame ends, so no frame ever mixes two configurations. An active-low one-clock frame pulse marks the start of each frame, so that cascaded column drivers can stay aligned with the row scan.

Top module: `lcd_row_scanner`

## Requirements
- R1: After reset, `row_sel` selects row 0, `col_out` is all zero (blank), `sync_n` is high, the active scan depth is 32 rows and the active top bank is 0.
- R2: `scan_tick` high at a clock edge advances the scan by one row. With `scan_tick` low, `row_sel` and the scan position hold.
- R3: The active `depth_sel` sets the frame length: 00 gives 8 rows, 01 gives 16, 10 gives 24 and 11 gives 32. The tick that leaves the last row returns the scan to row 0.
- R4: `sync_n` is low for exactly one clock, starting at the edge where the scan returns to row 0, and is high at all other times.
- R5: On scan row r, the columns show memory line (8·B + r) mod 32, where B is the active `first_bank`, so the scan wraps from bank 3 to bank 0.
- R6: The active `disp_mode` gives the columns as follows: 00 forces all zeros, 01 passes the line through, 10 forces all ones, and 11 inverts the line.
- R7: `depth_sel`, `first_bank` and `disp_mode` are captured only on the tick that ends a frame. A change in the middle of a frame has no effect on the outputs until the next frame starts.
- R8: With `ram_we` high at a clock edge, `ram_wdata` is stored at line `ram_waddr`. If that line is on display, it appears on the columns after that same edge.
- R9: `row_sel` is always one-hot, with bit k meaning display row k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_tick | input | 1 | Advance the scan by one row |
| depth_sel | input | 2 | Requested scan depth code |
| first_bank | input | 2 | Requested bank for the top display row |
| disp_mode | input | 2 | Requested display status code |
| ram_we | input | 1 | Display memory write strobe |
| ram_waddr | input | 5 | Display memory line to write |
| ram_wdata | input | 40 | Pixel line to write |
| row_sel | output | 32 | One-hot row select |
| col_out | output | 40 | Column pixel data for the selected row |
| sync_n | output | 1 | Active-low frame start pulse |

## Verification
The case hardest to reach from the ports is a new configuration arriving while a frame of the old one is still running. The outputs must keep the old depth, bank and status until the wrapping tick. After that tick they must take up the new settings at once. The stimulus reaches this for every combination of the three 2-bit settings. It presents each new combination right after a frame boundary, then walks the old frame row by row to the next boundary. This also runs every bank-wrap path for every depth. A second directed case writes the line that is on display in the middle of a frame.

// File: rtl/lcdscan_pkg.sv
// Shared types for the row scanner: display status codes and the
// bundle of frame settings that is captured at each frame boundary.
package lcdscan_pkg;

    typedef enum logic [1:0] {
        DISP_BLANK   = 2'b00,
        DISP_NORMAL  = 2'b01,
        DISP_ALLON   = 2'b10,
        DISP_INVERSE = 2'b11
    } disp_mode_e;

    typedef struct packed {
        logic [1:0] depth_sel;
        logic [1:0] first_bank;
        disp_mode_e disp;
    } scan_cfg_t;

    localparam scan_cfg_t CFG_AT_RESET = '{depth_sel: 2'b11, first_bank: 2'b00, disp: DISP_BLANK};

endpackage

// File: rtl/lcdscan_sequencer.sv
// Row sequencer: counts scan rows on each tick and wraps after the last
// row of the active depth. It captures new frame settings on the wrapping
// tick and issues the active-low frame pulse for one clock.
// Assumes the depth is (depth_sel+1) banks of ROWS_PER_BANK rows.
module lcdscan_sequencer
    import lcdscan_pkg::*;
#(
    parameter int ROWS_PER_BANK = 8,
    parameter int BANKS         = 4,
    localparam int LINES        = BANKS * ROWS_PER_BANK,
    localparam int RW           = $clog2(LINES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scan_tick,
    input  scan_cfg_t       cfg_in,
    output scan_cfg_t       cfg_act,
    output logic [RW-1:0]   scan_row,
    output logic            sync_n
);

    logic [RW-1:0] last_row;

    // Last row index of the active frame length.
    always_comb begin
        last_row = RW'((32'(cfg_act.depth_sel) + 1) * ROWS_PER_BANK - 1);
    end

    // Row counter, setting capture at wrap, and frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_row <= '0;
            cfg_act  <= CFG_AT_RESET;
            sync_n   <= 1'b1;
        end else begin
            sync_n <= 1'b1;
            if (scan_tick) begin
                if (scan_row == last_row) begin
                    scan_row <= '0;
                    cfg_act  <= cfg_in;
                    sync_n   <= 1'b0;
                end else begin
                    scan_row <= scan_row + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lcdscan_ram.sv
// Display memory: LINES lines of COLS bits, one synchronous write port and
// one combinational read port. The contents are not reset.
module lcdscan_ram #(
    parameter int COLS  = 40,
    parameter int LINES = 32,
    localparam int AW   = $clog2(LINES)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [COLS-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [COLS-1:0] rd_data
);

    logic [COLS-1:0] mem [LINES];

    // Store one pixel line per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the line that is addressed for display.
    always_comb begin
        rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/lcdscan_row_decode.sv
// Turns the scan row index into a one-hot row select, one comparator per row.
module lcdscan_row_decode #(
    parameter int LINES = 32,
    localparam int RW   = $clog2(LINES)
) (
    input  logic [RW-1:0]    scan_row,
    output logic [LINES-1:0] row_sel
);

    for (genvar g = 0; g < LINES; g++) begin : g_row
        assign row_sel[g] = (scan_row == RW'(g));
    end

endmodule

// File: rtl/lcdscan_col_shaper.sv
// Applies the display status to a raw pixel line: blank, pass, all on, invert.
module lcdscan_col_shaper
    import lcdscan_pkg::*;
#(
    parameter int COLS = 40
) (
    input  disp_mode_e      disp,
    input  logic [COLS-1:0] raw,
    output logic [COLS-1:0] cols
);

    // Select the column image for the active status.
    always_comb begin
        unique case (disp)
            DISP_BLANK:   cols = '0;
            DISP_NORMAL:  cols = raw;
            DISP_ALLON:   cols = '1;
            DISP_INVERSE: cols = ~raw;
            default:      cols = '0;
        endcase
    end

endmodule

// File: rtl/lcd_row_scanner.sv
// Top of the row scanner. Ties together the sequencer, the display memory,
// the row decoder and the column shaper. The memory line shown on a row is
// the top bank offset plus the scan row, taken modulo the memory depth.
// Assumes settings on the register side are steady or may change at any
// time; they are used only from the next frame.
module lcd_row_scanner
    import lcdscan_pkg::*;
#(
    parameter int COLS          = 40,
    parameter int ROWS_PER_BANK = 8,
    localparam int BANKS        = 4,
    localparam int LINES        = BANKS * ROWS_PER_BANK,
    localparam int AW           = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic [1:0]       depth_sel,
    input  logic [1:0]       first_bank,
    input  logic [1:0]       disp_mode,
    input  logic             ram_we,
    input  logic [AW-1:0]    ram_waddr,
    input  logic [COLS-1:0]  ram_wdata,
    output logic [LINES-1:0] row_sel,
    output logic [COLS-1:0]  col_out,
    output logic             sync_n
);

    scan_cfg_t       cfg_req;
    scan_cfg_t       cfg_act;
    logic [AW-1:0]   scan_row;
    logic [AW:0]     line_sum;
    logic [AW-1:0]   line_addr;
    logic [COLS-1:0] line_data;

    // Bundle the requested settings.
    always_comb begin
        cfg_req.depth_sel  = depth_sel;
        cfg_req.first_bank = first_bank;
        cfg_req.disp       = disp_mode_e'(disp_mode);
    end

    lcdscan_sequencer #(
        .ROWS_PER_BANK (ROWS_PER_BANK),
        .BANKS         (BANKS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .cfg_in    (cfg_req),
        .cfg_act   (cfg_act),
        .scan_row  (scan_row),
        .sync_n    (sync_n)
    );

    // Memory line for the current row: bank offset plus row, wrapped once.
    always_comb begin
        line_sum = (AW+1)'(cfg_act.first_bank) * (AW+1)'(ROWS_PER_BANK) + (AW+1)'(scan_row);
        if (line_sum >= (AW+1)'(LINES)) begin
            line_addr = AW'(line_sum - (AW+1)'(LINES));
        end else begin
            line_addr = AW'(line_sum);
        end
    end

    lcdscan_ram #(
        .COLS  (COLS),
        .LINES (LINES)
    ) ram_i (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_addr (ram_waddr),
        .wr_data (ram_wdata),
        .rd_addr (line_addr),
        .rd_data (line_data)
    );

    lcdscan_row_decode #(
        .LINES (LINES)
    ) rdec_i (
        .scan_row (scan_row),
        .row_sel  (row_sel)
    );

    lcdscan_col_shaper #(
        .COLS (COLS)
    ) shp_i (
        .disp (cfg_act.disp),
        .raw  (line_data),
        .cols (col_out)
    );

endmodule

// File: rtl/lcdscan_checker.sv
// Property checks for the row scanner, attached to the top by bind.
module lcdscan_checker
    import lcdscan_pkg::*;
#(
    parameter int COLS  = 40,
    parameter int LINES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_tick,
    input logic [LINES-1:0] row_sel,
    input logic [COLS-1:0]  col_out,
    input logic             sync_n,
    input scan_cfg_t        cfg_act
);

    assert_row_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1);

    assert_sync_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |=> sync_n);

    assert_sync_row0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |-> row_sel[0]);

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(row_sel));

    assert_blank_cols_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act.disp == DISP_BLANK) |-> (col_out == '0));

    assert_allon_cols_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_act.disp == DISP_ALLON) |-> (&col_out));

    assert_cfg_frame_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |-> $stable(cfg_act));

endmodule

bind lcd_row_scanner lcdscan_checker #(
    .COLS  (COLS),
    .LINES (LINES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .row_sel   (row_sel),
    .col_out   (col_out),
    .sync_n    (sync_n),
    .cfg_act   (cfg_act)
);

// File: tb/lcd_row_scanner_tb.sv
`timescale 1ns/1ps
module lcd_row_scanner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0;
    logic [1:0]  depth_sel = 2'b11;
    logic [1:0]  first_bank = 2'b00;
    logic [1:0]  disp_mode = 2'b00;
    logic        ram_we = 1'b0;
    logic [4:0]  ram_waddr = '0;
    logic [39:0] ram_wdata = '0;
    logic [31:0] row_sel;
    logic [39:0] col_out;
    logic        sync_n;

    int total = 0;
    int bad = 0;
    int act_m = 3, act_b = 0, act_e = 0;
    int exp_row = 0;
    logic [39:0] model [32];
    logic [31:0] held;

    always #4 clk = ~clk;

    lcd_row_scanner dut_i (
        .clk (clk), .rst_n (rst_n), .scan_tick (scan_tick),
        .depth_sel (depth_sel), .first_bank (first_bank), .disp_mode (disp_mode),
        .ram_we (ram_we), .ram_waddr (ram_waddr), .ram_wdata (ram_wdata),
        .row_sel (row_sel), .col_out (col_out), .sync_n (sync_n)
    );

    function automatic logic [39:0] pat(int a);
        return {8'(a * 29 + 3), 32'(a * 32'h9E37_79B1) ^ 32'h0F0F_1234};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Columns expected for the bench's own model of the active settings.
    function automatic logic [39:0] exp_cols();
        logic [39:0] d;
        d = model[(act_b * 8 + exp_row) % 32];
        case (act_e)
            0: return '0;
            1: return d;
            2: return '1;
            default: return ~d;
        endcase
    endfunction

    task automatic check_now(bit wrapped);
        logic [39:0] ec;
        ec = exp_cols();
        chk(row_sel == (32'd1 << exp_row), "R3", 64'(row_sel), 64'(32'd1 << exp_row));
        chk(col_out == ec, (act_e == 1) ? "R5" : "R6", 64'(col_out), 64'(ec));
        chk(sync_n == !wrapped, "R4", 64'(sync_n), 64'(!wrapped));
    endtask

    // One tick; bench updates its expectation from the requirements.
    task automatic step(output bit wrapped);
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk) scan_tick = 1'b0;
        wrapped = (exp_row == (act_m + 1) * 8 - 1);
        if (wrapped) begin
            exp_row = 0;
            act_m = int'(depth_sel); act_b = int'(first_bank); act_e = int'(disp_mode);
        end else begin
            exp_row++;
        end
        check_now(wrapped);
    endtask

    task automatic run_to_wrap();
        bit w;
        w = 1'b0;
        while (!w) step(w);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(row_sel == 32'd1, "R1", 64'(row_sel), 64'd1);
        chk(col_out == '0, "R1", 64'(col_out), 64'd0);
        chk(sync_n == 1'b1, "R1", 64'(sync_n), 64'd1);
        // R8: fill memory, no ticks; R2: scan holds meanwhile
        for (int a = 0; a < 32; a++) begin
            model[a] = pat(a);
            ram_we = 1'b1; ram_waddr = 5'(a); ram_wdata = pat(a);
            @(negedge clk);
        end
        ram_we = 1'b0;
        chk(row_sel == 32'd1, "R2", 64'(row_sel), 64'd1);
        // Sweep every setting combination; each new one is requested while
        // the previous frame runs (R7), then shown for a whole frame.
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 4; b++) begin
                for (int e = 0; e < 4; e++) begin
                    depth_sel = 2'(m); first_bank = 2'(b); disp_mode = 2'(e);
                    run_to_wrap();
                end
            end
        end
        depth_sel = 2'b01; first_bank = 2'b11; disp_mode = 2'b01;
        run_to_wrap();
        run_to_wrap();
        // R4, R2: no ticks after a wrap; pulse ends, rows hold
        held = row_sel;
        repeat (3) @(negedge clk);
        chk(sync_n == 1'b1, "R4", 64'(sync_n), 64'd1);
        chk(row_sel == held, "R2", 64'(row_sel), 64'(held));
        // R8: write the line on display mid-frame (bank 3 row 3 = line 27)
        begin
            bit w;
            repeat (3) step(w);
        end
        ram_we = 1'b1; ram_waddr = 5'd27; ram_wdata = 40'hA5_5A0F_F0C3;
        model[27] = 40'hA5_5A0F_F0C3;
        @(negedge clk);
        ram_we = 1'b0;
        chk(col_out == 40'hA5_5A0F_F0C3, "R8", 64'(col_out), 64'hA5_5A0F_F0C3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule